// File: doc/BRIEF.md
# Pipelined ADC Stage-Code Alignment and Correction

This block sits behind the comparator stages of a nine-stage pipelined analog-to-digital converter. On every clock each stage presents a 2-bit decision code. The stages resolve one analog sample at staggered times, so the codes on the bus in one cycle belong to different samples. Stage k (k = 1..9) presents its code for a sample floor((k-1)/2) clocks after stage 1 does. A bank of per-stage shift registers re-times the codes so that all nine refer to the same sample.

The nine aligned codes are summed with a one-bit overlap between neighbours. The redundant bit in each of the first eight stages absorbs comparator decision errors, and the sum is clamped to the 10-bit range. A format select chooses offset-binary or two's-complement coding. Two output registers re-time the word onto the sample clock. A flag marks the point after reset where the pipeline has filled.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Stage k's code sits in bits [2k-1:2k-2] of `stage_codes_i`, and its code for a sample arrives floor((k-1)/2) clocks after stage 1's. The block combines codes that belong to one sample, never codes from neighbouring samples.
- R2: The combined value equals the sum over k = 1..9 of code_k * 2^(9-k). Different code sets with the same weighted sum give the same output: stage 1 = 01 with stage 2 = 10 gives 512, the same as stage 1 = 10 alone.
- R3: A weighted sum above 1023 is clamped to 1023 and never wraps. A sum of exactly 1023 passes through unchanged.
- R4: The result for a sample appears on `data_o` after the 7th rising edge, counting the edge that captures stage 1's code for that sample as the first. One new result follows on every clock.
- R5: With `twos_comp_i` low, the output is offset binary: a sum of 0 gives 0000000000, 512 gives 1000000000 and 1023 gives 1111111111.
- R6: With `twos_comp_i` high, the output is the offset-binary value with bit 9 inverted: 512 gives 0000000000, 0 gives 1000000000 and 1023 gives 0111111111.
- R7: `twos_comp_i` is captured by the first of the two output registers. A change before edge e shows on `data_o` only after edge e+1.
- R8: While `rst_i` is high at a rising edge, every delay, sum and output register clears, so `data_o` reads 0 and `valid_o` reads 0.
- R9: After reset is released, `valid_o` stays low for the first 6 rising edges, rises after the 7th, and then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock; all registers update on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| stage_codes_i | input | 18 | Raw stage codes, stage k in bits [2k-1:2k-2] |
| twos_comp_i | input | 1 | Output format: 0 offset binary, 1 two's complement |
| data_o | output | 10 | Corrected sample word |
| valid_o | output | 1 | High once the pipeline has filled after reset |

## Verification
A sample's word is due on `data_o` six edges after the edge that takes its stage 1 code. A format change is due one edge after the edge that first captures it. The flag is due after the 7th edge that follows reset release. The bench drives each cycle's staggered codes on the falling edge and reads the outputs on the next falling edge. For each cycle it computes which sample must be on the output by subtracting the fixed latency from the cycle index, so each comparison lands on the cycle in which the result is due.

// File: rtl/pac_pkg.sv
package pac_pkg;

   // Width of the corrected word: one overlap bit between neighbouring stages
   function automatic int out_width(input int n_stages, input int code_w);
      return (code_w - 1) * (n_stages - 1) + code_w;
   endfunction

   // Width that holds the unclamped sum without wrapping
   function automatic int sum_width(input int n_stages, input int code_w);
      return n_stages + code_w;
   endfunction

   // Shift-register depth that re-times stage idx (0-based) onto stage 0's sample
   function automatic int stage_depth(input int n_stages, input int lag_div, input int idx);
      return (n_stages - 1) / lag_div - idx / lag_div;
   endfunction

endpackage

// File: rtl/pac_stage_align.sv
module pac_stage_align #(
   parameter int N_STAGES = 9,
   parameter int CODE_W   = 2,
   parameter int LAG_DIV  = 2
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic [N_STAGES*CODE_W-1:0]   codes_i,
   output logic [N_STAGES*CODE_W-1:0]   aligned_o
);

   for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      localparam int DEPTH = pac_pkg::stage_depth(N_STAGES, LAG_DIV, i);

      if (DEPTH == 0) begin : g_pass
         // latest stage: already lines up with the oldest delayed codes
         assign aligned_o[i*CODE_W +: CODE_W] = codes_i[i*CODE_W +: CODE_W];
      end else begin : g_dly
         logic [CODE_W-1:0] sr [DEPTH];

         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               for (int j = 0; j < DEPTH; j++) sr[j] <= '0;
            end else begin
               sr[0] <= codes_i[i*CODE_W +: CODE_W];
               for (int j = 1; j < DEPTH; j++) sr[j] <= sr[j-1];
            end
         end

         assign aligned_o[i*CODE_W +: CODE_W] = sr[DEPTH-1];
      end
   end

endmodule

// File: rtl/pac_overlap_sum.sv
module pac_overlap_sum #(
   parameter int N_STAGES = 9,
   parameter int CODE_W   = 2,
   parameter int OUT_W    = 10,
   parameter int SUM_W    = 11
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic [N_STAGES*CODE_W-1:0]   aligned_i,
   output logic [SUM_W-1:0]             raw_sum_o,
   output logic [OUT_W-1:0]             sum_q_o
);

   localparam int          STEP    = CODE_W - 1;
   localparam logic [SUM_W-1:0] MAX_S = SUM_W'((1 << OUT_W) - 1);

   logic [OUT_W-1:0] clamp_d;

   always_comb begin
      raw_sum_o = '0;
      for (int i = 0; i < N_STAGES; i++) begin
         raw_sum_o = raw_sum_o
                   + (SUM_W'(aligned_i[i*CODE_W +: CODE_W]) << (STEP * (N_STAGES - 1 - i)));
      end
   end

   always_comb begin
      if (raw_sum_o > MAX_S) clamp_d = '1;
      else                   clamp_d = raw_sum_o[OUT_W-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) sum_q_o <= '0;
      else       sum_q_o <= clamp_d;
   end

endmodule

// File: rtl/pac_out_reg.sv
module pac_out_reg #(
   parameter int OUT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             twos_i,
   input  logic [OUT_W-1:0] sum_i,
   output logic [OUT_W-1:0] data_o
);

   logic [OUT_W-1:0] stage_a;
   logic [OUT_W-1:0] fmt_mask;

   assign fmt_mask = {twos_i, {(OUT_W-1){1'b0}}};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stage_a <= '0;
         data_o  <= '0;
      end else begin
         stage_a <= sum_i ^ fmt_mask;
         data_o  <= stage_a;
      end
   end

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
   parameter int N_STAGES = 9,
   parameter int CODE_W   = 2,
   parameter int LAG_DIV  = 2
) (
   input  logic                                          clk_i,
   input  logic                                          rst_i,
   input  logic [N_STAGES*CODE_W-1:0]                    stage_codes_i,
   input  logic                                          twos_comp_i,
   output logic [pac_pkg::out_width(N_STAGES,CODE_W)-1:0] data_o,
   output logic                                          valid_o
);

   localparam int OUT_W   = pac_pkg::out_width(N_STAGES, CODE_W);
   localparam int SUM_W   = pac_pkg::sum_width(N_STAGES, CODE_W);
   localparam int ALIGN_D = (N_STAGES - 1) / LAG_DIV;
   localparam int LATENCY = ALIGN_D + 3;
   localparam int CNT_W   = $clog2(LATENCY + 1);

   if (N_STAGES < 2) begin : g_chk_stages
      $error("pipe_adc_corrector: N_STAGES must be at least 2");
   end
   if (CODE_W < 2) begin : g_chk_code
      $error("pipe_adc_corrector: CODE_W must be at least 2 to carry a redundant bit");
   end
   if (LAG_DIV < 1) begin : g_chk_lag
      $error("pipe_adc_corrector: LAG_DIV must be at least 1");
   end

   logic [N_STAGES*CODE_W-1:0] aligned;
   logic [SUM_W-1:0]           raw_sum;
   logic [OUT_W-1:0]           sum_q;
   logic [CNT_W-1:0]           fill_cnt;

   pac_stage_align #(
      .N_STAGES (N_STAGES),
      .CODE_W   (CODE_W),
      .LAG_DIV  (LAG_DIV)
   ) u_align (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .codes_i   (stage_codes_i),
      .aligned_o (aligned)
   );

   pac_overlap_sum #(
      .N_STAGES (N_STAGES),
      .CODE_W   (CODE_W),
      .OUT_W    (OUT_W),
      .SUM_W    (SUM_W)
   ) u_sum (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .aligned_i (aligned),
      .raw_sum_o (raw_sum),
      .sum_q_o   (sum_q)
   );

   pac_out_reg #(
      .OUT_W (OUT_W)
   ) u_out (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .twos_i (twos_comp_i),
      .sum_i  (sum_q),
      .data_o (data_o)
   );

   // fill counter: stops at the latency and marks the output as trustworthy
   always_ff @(posedge clk_i) begin
      if (rst_i)                            fill_cnt <= '0;
      else if (fill_cnt != CNT_W'(LATENCY)) fill_cnt <= fill_cnt + 1'b1;
   end

   assign valid_o = (fill_cnt == CNT_W'(LATENCY));

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
   parameter int OUT_W = 10,
   parameter int SUM_W = 11
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             fmt_i,
   input logic [SUM_W-1:0] raw_sum,
   input logic [OUT_W-1:0] sum_q,
   input logic [OUT_W-1:0] data_o,
   input logic             valid_o
);

   localparam logic [SUM_W-1:0] MAX_S = SUM_W'((1 << OUT_W) - 1);

   // R3: an oversized sum lands in the sum register as all ones
   p_clamp_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (raw_sum > MAX_S) |=> (sum_q == '1));

   // R2: an in-range sum is registered unchanged
   p_pass_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (raw_sum <= MAX_S) |=> (sum_q == $past(raw_sum[OUT_W-1:0])));

   // R7: output equals the sum two edges back with the format captured then
   p_fmt_path_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> (data_o == ($past(sum_q, 2) ^ {$past(fmt_i, 2), {(OUT_W-1){1'b0}}})));

   // R9: once valid, stays valid until reset
   p_valid_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> valid_o);

endmodule

bind pipe_adc_corrector pac_checker #(
   .OUT_W (OUT_W),
   .SUM_W (SUM_W)
) u_pac_checker (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .fmt_i   (twos_comp_i),
   .raw_sum (raw_sum),
   .sum_q   (sum_q),
   .data_o  (data_o),
   .valid_o (valid_o)
);

// File: tb/pipe_adc_corrector_bench.sv
module pipe_adc_corrector_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic [17:0] codes;
   logic        fmt;
   logic [9:0]  dout;
   logic        vld;

   int n_checks = 0;
   int n_errors = 0;

   logic [17:0] samp [0:63];

   always #10 clk = ~clk;

   pipe_adc_corrector u_pipe_adc_corrector (
      .clk_i         (clk),
      .rst_i         (rst),
      .stage_codes_i (codes),
      .twos_comp_i   (fmt),
      .data_o        (dout),
      .valid_o       (vld)
   );

   task automatic check(input string req, input int act, input int exp_v);
      n_checks++;
      if (act != exp_v) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   // model of R2, R3, R5, R6
   function automatic int model(input logic [17:0] w, input logic f);
      int s = 0;
      for (int i = 0; i < 9; i++) s += int'(w[2*i +: 2]) << (8 - i);
      if (s > 1023) s = 1023;
      if (f) s = s ^ 512;
      return s;
   endfunction

   // R8: reset clears everything; leaves the bench at a falling edge with reset released
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      codes = '1;
      repeat (3) @(negedge clk);
      check("R8 data in reset", int'(dout), 0);
      check("R8 valid in reset", int'(vld), 0);
      rst = 1'b0;
      codes = '0;
   endtask

   // R1/R4/R9: stream n samples with staggered stage codes, check each at its due cycle
   task automatic run_stream(input int n, input logic f, input string tag);
      int bad = 0;
      do_reset();
      fmt = f;
      for (int c = 0; c < n + 7; c++) begin
         logic [17:0] w = '0;
         for (int i = 0; i < 9; i++) begin
            int s = c - i / 2;
            if (s >= 0 && s < n) w[2*i +: 2] = samp[s][2*i +: 2];
         end
         codes = w;
         @(posedge clk);
         @(negedge clk);
         if (vld != (c >= 6)) begin
            bad++;
            check({"R9 valid fill ", tag}, int'(vld), int'(c >= 6));
         end
         if (c >= 6 && c - 6 < n) begin
            if (int'(dout) != model(samp[c-6], f)) begin
               bad++;
               check({"R4 R1 stream ", tag}, int'(dout), model(samp[c-6], f));
            end
         end
      end
      check({"R4 R1 stream mismatches ", tag}, bad, 0);
   endtask

   task automatic fill_const(input int n, input logic [17:0] w);
      for (int s = 0; s < n; s++) samp[s] = w;
   endtask

   task automatic t_single(input logic [17:0] w, input logic f, input int exp_v, input string req);
      fill_const(3, w);
      run_stream(3, f, req);
      // run_stream ends with the last sample already checked; compare the model too
      check(req, model(w, f), exp_v);
   endtask

   task automatic t_random();
      for (int s = 0; s < 40; s++)
         samp[s] = 18'((s * 98317 + 12345) ^ (s << 7) ^ (s * s * 31));
      run_stream(40, 1'b0, "R1 R2 R5 random offset");
      run_stream(40, 1'b1, "R1 R2 R6 random twos");
   endtask

   // R7: format change takes one extra edge to reach the output
   task automatic t_fmt_switch();
      do_reset();
      fmt = 1'b0;
      codes = 18'h00002;           // every stage-1 code 10, others 0: sum 512
      repeat (10) @(negedge clk);
      check("R7 before switch", int'(dout), 512);
      fmt = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R7 one edge after switch", int'(dout), 512);
      @(posedge clk);
      @(negedge clk);
      check("R7 two edges after switch", int'(dout), 0);
   endtask

   // R8: mid-stream reset
   task automatic t_mid_reset();
      fmt = 1'b0;
      codes = 18'h3FFFF;
      repeat (10) @(negedge clk);
      check("R8 running before reset", int'(vld), 1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R8 data after reset edge", int'(dout), 0);
      check("R8 valid after reset edge", int'(vld), 0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      rst = 1'b1;
      codes = '0;
      fmt = 1'b0;
      // R5 R6 midscale, zero, full scale
      t_single(18'h00002, 1'b0, 512, "R5 midscale offset");
      t_single(18'h00002, 1'b1, 0, "R6 midscale twos");
      t_single(18'h00000, 1'b0, 0, "R5 zero offset");
      t_single(18'h00000, 1'b1, 512, "R6 zero twos");
      // R2 redundancy: stage1=01, stage2=10 equals stage1=10
      t_single(18'h00009, 1'b0, 512, "R2 redundant equal midscale");
      // R3 exact 1023, one over, and all ones
      t_single(18'h15557, 1'b0, 1023, "R3 exact full scale");
      t_single(18'h25557, 1'b0, 1023, "R3 one over clamps");
      t_single(18'h3FFFF, 1'b0, 1023, "R3 all ones clamps");
      t_single(18'h3FFFF, 1'b1, 511, "R6 R3 clamped twos");
      t_random();
      t_fmt_switch();
      t_mid_reset();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule